// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block walks one DMA channel through a single buffer transfer. When idle it accepts a load pulse carrying a source address, a destination address and two control words. After the load it presents the current source and destination addresses with their byte-lane strobes, and it moves both addresses by one step each time the surrounding bus logic reports an accepted beat. Handshaking with peripherals, arbitration between channels and descriptor fetching belong to neighbouring blocks.

Each side has its own data width and its own address mode. The mode is increment, decrement or fixed. The beat count is the transfer size field of control word A, counted in source-width units. Each accepted beat moves both addresses by the step of their own side. When the final beat is accepted the block returns to idle, pulses a buffer-complete output and sets the done flag in the control word it reflects. Chunk boundaries of one or four beats are flagged per side, so a bus master can place its burst ends there.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, busy, bufDone, widthErr and the whole of ctrlAOut are 0.
- R2: A load pulse while idle captures the inputs. From the next cycle srcAddr and dstAddr show the loaded addresses and busy is 1, provided the size field ctrlAIn[SIZE_W-1:0] (bits 15:0 at the default) is nonzero.
- R3: On each clock edge with busy and beatAck both high, each address moves by its step. The step is 1, 2 or 4 for width code 0, 1 or 2. Source width is ctrlA[25:24] and destination width is ctrlA[29:28]. The direction comes from ctrlB[25:24] for the source and ctrlB[29:28] for the destination: 0 adds the step, 1 subtracts it modulo 2^32, and 2 or 3 leaves the address unchanged.
- R4: The strobes follow the address and the width of their side. Byte width gives 4'b0001 shifted left by addr[1:0]. Halfword gives 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1. Word gives 4'b1111.
- R5: The edge that accepts beat number N, where N is the size field, clears busy. In the following cycle bufDone is high for exactly one cycle and ctrlAOut equals the loaded ctrlA with bit 31 forced to 1.
- R6: A load with a size field of 0 leaves busy at 0. In the next cycle bufDone pulses for one cycle and ctrlAOut[31] is 1.
- R7: A load while busy is ignored, and so is beatAck while idle. In both cases addresses, count and flags are unchanged.
- R8: Width code 3 on either side acts as word width (step 4, strobe 4'b1111). widthErr is 1 from the cycle after such a load until the next accepted load.
- R9: ctrlA bit 16 sets the source chunk size and bit 20 sets the destination chunk size (0 = one beat, 1 = four beats). With one-beat chunks, srcChunkEnd or dstChunkEnd is high on every beat. With four-beat chunks it is high on beats whose zero-based index is 3 mod 4, and on the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start a transfer with the values below (taken only when idle) |
| srcAddrIn | input | 32 | Initial source address |
| dstAddrIn | input | 32 | Initial destination address |
| ctrlAIn | input | 32 | Size, widths and chunk bits |
| ctrlBIn | input | 32 | Source and destination address modes |
| beatAck | input | 1 | Current beat accepted by the bus |
| busy | output | 1 | Transfer in progress |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| srcStrb | output | 4 | Source byte-lane strobes |
| dstStrb | output | 4 | Destination byte-lane strobes |
| srcChunkEnd | output | 1 | Current beat closes a source chunk |
| dstChunkEnd | output | 1 | Current beat closes a destination chunk |
| bufDone | output | 1 | One-cycle buffer-complete pulse |
| ctrlAOut | output | 32 | Loaded control word A with the done flag in bit 31 |
| widthErr | output | 1 | A reserved width code was loaded |

## Verification
Each output has a fixed delay after its stimulus:
- Loaded addresses, busy and widthErr become visible one edge after the load.
- A beat's addresses, strobes and chunk flags are valid in the cycle in which beatAck is high, and they move on one edge later.
- bufDone and the done flag appear one edge after the final accepting edge, or one edge after a zero-size load. bufDone drops again after one more edge.

The driver computes each beat's expected values from the requirements and queues them. A monitor pops one queue entry at the falling edge of every cycle where busy and beatAck are both high. The driver samples completion flags 1 ns after the rising edge that should have produced them.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // Width codes shared by both sides
  localparam logic [1:0] W_BYTE = 2'd0;
  localparam logic [1:0] W_HALF = 2'd1;
  localparam logic [1:0] W_WORD = 2'd2;
  localparam logic [1:0] W_RSVD = 2'd3;

  // Address update modes
  localparam logic [1:0] M_INC = 2'd0;
  localparam logic [1:0] M_DEC = 2'd1;

  // Field positions inside the control words
  localparam int SRC_WIDTH_LSB = 24;
  localparam int DST_WIDTH_LSB = 28;
  localparam int SRC_MODE_LSB  = 24;
  localparam int DST_MODE_LSB  = 28;
  localparam int SRC_CHUNK_BIT = 16;
  localparam int DST_CHUNK_BIT = 20;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic stepEn;
  } seqCmd_t;

endpackage

// File: rtl/dma_seq_side.sv
module dma_seq_side
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        widthIn,
  input  logic [1:0]        modeIn,
  output logic [ADDR_W-1:0] addr,
  output logic [STRB_W-1:0] strb
);
  localparam int LANE_W = $clog2(STRB_W);

  logic [1:0]        widthQ;
  logic [1:0]        modeQ;
  logic [ADDR_W-1:0] stepAmt;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    case (widthQ)
      W_BYTE:  stepAmt = ADDR_W'(1);
      W_HALF:  stepAmt = ADDR_W'(2);
      default: stepAmt = ADDR_W'(4);
    endcase
  end

  always_comb begin
    case (modeQ)
      M_INC:   addrNext = addr + stepAmt;
      M_DEC:   addrNext = addr - stepAmt;
      default: addrNext = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      widthQ <= W_BYTE;
      modeQ  <= M_INC;
    end else if (cmd.loadEn) begin
      addr   <= addrIn;
      widthQ <= widthIn;
      modeQ  <= modeIn;
    end else if (cmd.stepEn) begin
      addr   <= addrNext;
    end
  end

  for (genvar g = 0; g < STRB_W; g++) begin : gLane
    localparam logic [LANE_W-1:0] LANE = LANE_W'(g);
    logic byteHit;
    logic halfHit;
    assign byteHit = (addr[LANE_W-1:0] == LANE);
    assign halfHit = (addr[LANE_W-1:1] == LANE[LANE_W-1:1]);
    assign strb[g] = (widthQ == W_BYTE) ? byteHit :
                     (widthQ == W_HALF) ? halfHit : 1'b1;
  end

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] srcAddrIn,
  input  logic [ADDR_W-1:0] dstAddrIn,
  input  logic [1:0]        srcWidthIn,
  input  logic [1:0]        dstWidthIn,
  input  logic [1:0]        srcModeIn,
  input  logic [1:0]        dstModeIn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [STRB_W-1:0] srcStrb,
  output logic [STRB_W-1:0] dstStrb,
  output logic              widthErr
);
  localparam int SIDES = 2;

  logic [ADDR_W-1:0] sideAddrIn [SIDES];
  logic [1:0]        sideWidth  [SIDES];
  logic [1:0]        sideMode   [SIDES];
  logic [ADDR_W-1:0] sideAddr   [SIDES];
  logic [STRB_W-1:0] sideStrb   [SIDES];

  assign sideAddrIn[0] = srcAddrIn;
  assign sideAddrIn[1] = dstAddrIn;
  assign sideWidth[0]  = srcWidthIn;
  assign sideWidth[1]  = dstWidthIn;
  assign sideMode[0]   = srcModeIn;
  assign sideMode[1]   = dstModeIn;

  for (genvar s = 0; s < SIDES; s++) begin : gSide
    dma_seq_side #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_side (
      .clk    (clk),
      .rstN   (rstN),
      .cmd    (cmd),
      .addrIn (sideAddrIn[s]),
      .widthIn(sideWidth[s]),
      .modeIn (sideMode[s]),
      .addr   (sideAddr[s]),
      .strb   (sideStrb[s])
    );
  end

  assign srcAddr = sideAddr[0];
  assign dstAddr = sideAddr[1];
  assign srcStrb = sideStrb[0];
  assign dstStrb = sideStrb[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           widthErr <= 1'b0;
    else if (cmd.loadEn) widthErr <= (srcWidthIn == W_RSVD) || (dstWidthIn == W_RSVD);
  end

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              beatAck,
  input  logic [CTRL_W-1:0] ctrlAIn,
  output seqCmd_t           cmd,
  output logic              busy,
  output logic              bufDone,
  output logic              srcChunkEnd,
  output logic              dstChunkEnd,
  output logic [CTRL_W-1:0] ctrlAOut
);
  localparam int KEEP_W = CTRL_W - 1;

  logic [KEEP_W-1:0] ctrlQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [SIZE_W-1:0] beatIdx;
  logic              doneFlag;
  logic              lastBeat;
  logic              quadEnd;
  logic [SIZE_W-1:0] sizeIn;
  logic              unusedDoneIn;

  assign unusedDoneIn = ctrlAIn[CTRL_W-1];
  assign sizeIn       = ctrlAIn[SIZE_W-1:0];
  assign cmd.loadEn   = load && !busy;
  assign cmd.stepEn   = busy && beatAck;
  assign lastBeat     = (beatIdx == sizeQ - SIZE_W'(1));
  assign quadEnd      = (beatIdx[1:0] == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      sizeQ    <= '0;
      beatIdx  <= '0;
      busy     <= 1'b0;
      doneFlag <= 1'b0;
      bufDone  <= 1'b0;
    end else if (cmd.loadEn) begin
      ctrlQ    <= ctrlAIn[KEEP_W-1:0];
      sizeQ    <= sizeIn;
      beatIdx  <= '0;
      busy     <= (sizeIn != '0);
      doneFlag <= (sizeIn == '0);
      bufDone  <= (sizeIn == '0);
    end else if (cmd.stepEn) begin
      beatIdx  <= beatIdx + SIZE_W'(1);
      bufDone  <= lastBeat;
      if (lastBeat) begin
        busy     <= 1'b0;
        doneFlag <= 1'b1;
      end
    end else begin
      bufDone  <= 1'b0;
    end
  end

  assign srcChunkEnd = busy && (!ctrlQ[SRC_CHUNK_BIT] || quadEnd || lastBeat);
  assign dstChunkEnd = busy && (!ctrlQ[DST_CHUNK_BIT] || quadEnd || lastBeat);
  assign ctrlAOut    = {doneFlag, ctrlQ};

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] srcAddrIn,
  input  logic [ADDR_W-1:0] dstAddrIn,
  input  logic [31:0]       ctrlAIn,
  input  logic [31:0]       ctrlBIn,
  input  logic              beatAck,
  output logic              busy,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [STRB_W-1:0] srcStrb,
  output logic [STRB_W-1:0] dstStrb,
  output logic              srcChunkEnd,
  output logic              dstChunkEnd,
  output logic              bufDone,
  output logic [31:0]       ctrlAOut,
  output logic              widthErr
);
  seqCmd_t cmd;
  logic    unusedCtrlB;

  assign unusedCtrlB = ^{ctrlBIn[31:30], ctrlBIn[27:26], ctrlBIn[23:0]};

  dma_seq_ctrl #(.SIZE_W(SIZE_W), .CTRL_W(32)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .load       (load),
    .beatAck    (beatAck),
    .ctrlAIn    (ctrlAIn),
    .cmd        (cmd),
    .busy       (busy),
    .bufDone    (bufDone),
    .srcChunkEnd(srcChunkEnd),
    .dstChunkEnd(dstChunkEnd),
    .ctrlAOut   (ctrlAOut)
  );

  dma_seq_datapath #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .srcAddrIn (srcAddrIn),
    .dstAddrIn (dstAddrIn),
    .srcWidthIn(ctrlAIn[SRC_WIDTH_LSB+1:SRC_WIDTH_LSB]),
    .dstWidthIn(ctrlAIn[DST_WIDTH_LSB+1:DST_WIDTH_LSB]),
    .srcModeIn (ctrlBIn[SRC_MODE_LSB+1:SRC_MODE_LSB]),
    .dstModeIn (ctrlBIn[DST_MODE_LSB+1:DST_MODE_LSB]),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .srcStrb   (srcStrb),
    .dstStrb   (dstStrb),
    .widthErr  (widthErr)
  );

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              load,
  input logic              beatAck,
  input logic              busy,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input logic [STRB_W-1:0] srcStrb,
  input logic [STRB_W-1:0] dstStrb,
  input logic              bufDone,
  input logic [31:0]       ctrlAOut,
  input logic              widthErr
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    bufDone |-> !busy) else $error("AST_DONE_IDLE"); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    bufDone |-> ctrlAOut[31]) else $error("AST_DONE_FLAG"); // R6

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> bufDone) else $error("AST_BUSY_FALL"); // R5

  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !beatAck) |=> (busy && $stable(srcAddr) && $stable(dstAddr)))
    else $error("AST_HOLD_NO_ACK"); // R7

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !load && beatAck) |=> (!bufDone && $stable(srcAddr) && $stable(dstAddr)))
    else $error("AST_IDLE_ACK"); // R7

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(widthErr)) else $error("AST_ERR_HOLD"); // R8

  AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (($countones(srcStrb) inside {1, 2, 4}) && ($countones(dstStrb) inside {1, 2, 4})))
    else $error("AST_STRB_SHAPE"); // R4
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .load    (load),
  .beatAck (beatAck),
  .busy    (busy),
  .srcAddr (srcAddr),
  .dstAddr (dstAddr),
  .srcStrb (srcStrb),
  .dstStrb (dstStrb),
  .bufDone (bufDone),
  .ctrlAOut(ctrlAOut),
  .widthErr(widthErr)
);

// File: tb/dma_addr_seq_tb.sv
`timescale 1ns/1ps
module dma_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        load = 1'b0;
  logic [31:0] srcAddrIn = '0, dstAddrIn = '0, ctrlAIn = '0, ctrlBIn = '0;
  logic        beatAck = 1'b0;
  logic        busy, srcChunkEnd, dstChunkEnd, bufDone, widthErr;
  logic [31:0] srcAddr, dstAddr, ctrlAOut;
  logic [3:0]  srcStrb, dstStrb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] d;
    logic [3:0]  ss;
    logic [3:0]  ds;
    logic        sce;
    logic        dce;
  } beat_t;
  beat_t expQ[$];

  always #2.5 clk = ~clk;

  dma_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .load(load), .srcAddrIn(srcAddrIn), .dstAddrIn(dstAddrIn),
    .ctrlAIn(ctrlAIn), .ctrlBIn(ctrlBIn), .beatAck(beatAck), .busy(busy),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcStrb(srcStrb), .dstStrb(dstStrb),
    .srcChunkEnd(srcChunkEnd), .dstChunkEnd(dstChunkEnd), .bufDone(bufDone),
    .ctrlAOut(ctrlAOut), .widthErr(widthErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stepOf(input logic [1:0] w);
    return (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] nextAddr(input logic [31:0] a, input logic [1:0] w, input logic [1:0] m);
    if (m == 2'd0) return a + stepOf(w);
    if (m == 2'd1) return a - stepOf(w);
    return a;
  endfunction

  function automatic logic [3:0] strbOf(input logic [31:0] a, input logic [1:0] w);
    if (w == 2'd0) return 4'b0001 << a[1:0];
    if (w == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] mkA(input int n, input logic [1:0] sw, input logic [1:0] dw,
                                      input bit sc, input bit dc);
    logic [31:0] a = '0;
    a[15:0] = n[15:0]; a[25:24] = sw; a[29:28] = dw; a[16] = sc; a[20] = dc;
    return a;
  endfunction

  function automatic logic [31:0] mkB(input logic [1:0] sm, input logic [1:0] dm);
    logic [31:0] b = '0;
    b[25:24] = sm; b[29:28] = dm;
    return b;
  endfunction

  // Monitor: compare each accepted beat against the queue
  always @(negedge clk) begin
    if (rstN && busy && beatAck) begin
      if (expQ.size() == 0) begin
        chk("R5 extra beat", 64'd1, 64'd0);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        chk("R3 srcAddr", {32'd0, srcAddr}, {32'd0, e.s});
        chk("R3 dstAddr", {32'd0, dstAddr}, {32'd0, e.d});
        chk("R4 srcStrb", {60'd0, srcStrb}, {60'd0, e.ss});
        chk("R4 dstStrb", {60'd0, dstStrb}, {60'd0, e.ds});
        chk("R9 chunkEnd", {62'd0, srcChunkEnd, dstChunkEnd}, {62'd0, e.sce, e.dce});
      end
    end
  end

  // Driver: queue expected beats, load, feed beatAck, check completion
  task automatic runXfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] a,
                         input logic [31:0] b, input bit gaps, input bit poke);
    int n = int'(a[15:0]);
    logic [31:0] cs = s, cd = d;
    logic [1:0] sw = a[25:24], dw = a[29:28];
    logic werr = (sw == 2'd3) || (dw == 2'd3);
    for (int i = 0; i < n; i++) begin
      beat_t e;
      e.s = cs; e.d = cd;
      e.ss = strbOf(cs, sw); e.ds = strbOf(cd, dw);
      e.sce = !a[16] || (i % 4 == 3) || (i == n - 1);
      e.dce = !a[20] || (i % 4 == 3) || (i == n - 1);
      expQ.push_back(e);
      cs = nextAddr(cs, sw, b[25:24]);
      cd = nextAddr(cd, dw, b[29:28]);
    end
    @(posedge clk); #1;
    load = 1'b1; srcAddrIn = s; dstAddrIn = d; ctrlAIn = a; ctrlBIn = b;
    @(posedge clk); #1;
    load = 1'b0;
    if (n == 0) begin
      chk("R6 busy", {63'd0, busy}, 64'd0);
      chk("R6 bufDone", {63'd0, bufDone}, 64'd1);
      chk("R6 ctrlAOut", {32'd0, ctrlAOut}, {32'd0, 1'b1, a[30:0]});
      @(posedge clk); #1;
      chk("R6 bufDone pulse", {63'd0, bufDone}, 64'd0);
      return;
    end
    chk("R2 busy", {63'd0, busy}, 64'd1);
    chk("R2 srcAddr", {32'd0, srcAddr}, {32'd0, s});
    chk("R2 dstAddr", {32'd0, dstAddr}, {32'd0, d});
    chk("R8 widthErr", {63'd0, widthErr}, {63'd0, werr});
    for (int i = 0; i < n; i++) begin
      if ((gaps && (i % 2 == 1)) || (poke && i == 1)) begin
        beatAck = 1'b0;
        if (poke && i == 1) begin
          load = 1'b1; srcAddrIn = 32'hDEAD_0000; dstAddrIn = 32'hBEEF_0000;
          ctrlAIn = mkA(0, 2'd0, 2'd0, 0, 0); ctrlBIn = '0;
        end
        @(posedge clk); #1;
        load = 1'b0;
      end
      beatAck = 1'b1;
      @(posedge clk); #1;
    end
    beatAck = 1'b0;
    chk("R5 busy cleared", {63'd0, busy}, 64'd0);
    chk("R5 bufDone", {63'd0, bufDone}, 64'd1);
    chk("R5 ctrlAOut", {32'd0, ctrlAOut}, {32'd0, 1'b1, a[30:0]});
    chk("R5 all beats seen", 64'(expQ.size()), 64'd0);
    if (poke) chk("R7 widthErr kept", {63'd0, widthErr}, {63'd0, werr});
    @(posedge clk); #1;
    chk("R5 bufDone pulse", {63'd0, bufDone}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] holdS, holdD;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 bufDone", {63'd0, bufDone}, 64'd0);
    chk("R1 ctrlAOut", {32'd0, ctrlAOut}, 64'd0);
    chk("R1 widthErr", {63'd0, widthErr}, 64'd0);
    rstN = 1'b1;

    // byte incr source with 4-beat chunks, word incr destination
    runXfer(32'h1000_0001, 32'h2000_0000, mkA(6, 2'd0, 2'd2, 1, 0), mkB(2'd0, 2'd0), 0, 0);
    // halfword decr source, fixed byte destination, gaps between beats
    runXfer(32'h3000_0006, 32'h4000_0003, mkA(5, 2'd1, 2'd0, 0, 1), mkB(2'd1, 2'd2), 1, 0);
    // zero size
    runXfer(32'h5000_0000, 32'h6000_0000, mkA(0, 2'd2, 2'd2, 0, 0), mkB(2'd0, 2'd0), 0, 0);
    // reserved source width, decrement wrap, load while busy
    runXfer(32'h0000_0002, 32'h0000_0004, mkA(3, 2'd3, 2'd2, 0, 0), mkB(2'd0, 2'd1), 0, 1);
    // byte decr wrapping through zero, halfword incr odd address
    runXfer(32'h0000_0001, 32'h0000_0013, mkA(9, 2'd0, 2'd1, 1, 1), mkB(2'd1, 2'd0), 1, 0);

    // beatAck while idle
    holdS = srcAddr; holdD = dstAddr;
    beatAck = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    beatAck = 1'b0;
    chk("R7 idle srcAddr", {32'd0, srcAddr}, {32'd0, holdS});
    chk("R7 idle dstAddr", {32'd0, dstAddr}, {32'd0, holdD});
    chk("R7 idle bufDone", {63'd0, bufDone}, 64'd0);
    chk("R7 idle busy", {63'd0, busy}, 64'd0);

    // a normal load clears widthErr
    runXfer(32'h7000_0000, 32'h7100_0000, mkA(2, 2'd2, 2'd1, 0, 0), mkB(2'd0, 2'd0), 0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule